// File: doc/BRIEF.md
# Condition-Field Fail-First Truncation Unit

This unit runs alongside a vector pipeline that executes instructions whose only result is a 4-bit condition field per element. Software starts it with the instruction's mode word, the vector length and a description of the destination operand. It then accepts one result field per cycle on a valid/ready handshake. Each field is tested by comparing one selected bit against an invert flag. Depending on the mode, the unit does one of three things:

- it passes every element through;
- it shortens the vector at the first failing element (data-dependent fail-first);
- it gates each element's write on its own test result (predicate-result).

The bit under test is chosen in one of two ways. For single-bit operations that address the destination with five bits, it is the bit the operation just wrote, given by the low two destination bits. For whole-field operations that address the destination with three bits, a 2-bit selector taken from the mode word chooses it. The unit reports a write enable per element, with a flag that turns the write into an all-zero field. It also reports the resulting vector length, an error for the reserved mode, and a one-cycle completion pulse.

Top module: `crfield_trunc`

## Requirements
- R1: After reset the unit is idle: `elem_ready_o`, `wr_en_o`, `wr_zero_o`, `done_o` and `err_o` are all low.
- R2: The kind is `{mode_i[19], mode_i[20]}`. Kind 2'b00 is pass-through: every element 0..VL-1 is written with `wr_zero_o` low, and the final length equals `vl_i`.
- R3: For a bit operation (`is_field_i`=0), the tested bit is `elem_field_i[dest_lo_i]`, where bit 0 is position 0. An element passes when that bit differs from the invert flag `mode_i[21]`.
- R4: For a field operation (`is_field_i`=1), the tested position is `{mode_i[22], mode_i[23]}`, and `dest_lo_i` is ignored. The inclusive flag `mode_i[5]` is treated as clear. The zeroing flag is `mode_i[4]`. For bit operations the zeroing flag is `mode_i[22]`.
- R5: Kind 2'b01 is fail-first. If the first failing element is i and the inclusive flag is clear, the final length is i, and element i and every later element are not written.
- R6: Fail-first with the inclusive flag set (bit operations only): failing element i is written, and the final length is i+1.
- R7: Fail-first with zeroing set: every index from the final length up to VL-1 is written with `wr_zero_o` high, one per cycle in ascending order. Done is raised with the last of these writes.
- R8: Fail-first with no failing element leaves the length at `vl_i`, and all elements are written.
- R9: Kind 2'b11 is predicate-result. The length is never changed. A passing element is written normally. A failing element is not written, or it is written as zero when zeroing is set.
- R10: Kind 2'b10 is reserved. It raises `err_o` together with `done_o` one cycle after start, with no writes, and the final length equals `vl_i`.
- R11: A `vl_i` of zero gives `done_o` one cycle after start, with no writes and a final length of zero.
- R12: One element is consumed per cycle in which both `elem_valid_i` and `elem_ready_o` are high. Its write appears in the next cycle. `done_o` is a single-cycle pulse, raised with the last write, or with the failing element when nothing follows it, and `elem_ready_o` is low while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin an operation (honoured only while idle) |
| mode_i | input | 24 | Instruction mode word |
| is_field_i | input | 1 | 1: whole-field operand, 0: single-bit operand |
| dest_lo_i | input | 2 | Low two bits of the single-bit destination |
| vl_i | input | VL_W | Vector length at start |
| elem_valid_i | input | 1 | Result field present |
| elem_field_i | input | 4 | Condition field of the current element |
| elem_ready_o | output | 1 | Unit accepts an element this cycle |
| wr_en_o | output | 1 | Write element `wr_idx_o` |
| wr_zero_o | output | 1 | The write carries an all-zero field |
| wr_idx_o | output | VL_W | Index of the element being written |
| vl_o | output | VL_W | Resulting vector length, valid from `done_o` onwards |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Reserved mode, pulsed with `done_o` |

## Verification
The same eight fields are replayed under every mode. The kind then decides whether the outcome is a full write, a shortened vector or a sparse write mask.

- Different destination bits and selector values pick different columns of those fields, so a selector taken from the wrong place gives a different first-failure index.
- Exclusive and inclusive runs that share the same fields differ by exactly one element.
- Zeroing runs differ from plain runs only in the tail.
- Failures at index 0 and at the last index exercise the two truncation edges.
- Gapped valid patterns show that truncation counts handshakes, not cycles.

// File: rtl/crt_pkg.sv
package crt_pkg;

    localparam int MODE_W   = 24;
    localparam int B_DZ_FLD = 4;
    localparam int B_VLI    = 5;
    localparam int B_KIND_H = 19;
    localparam int B_KIND_L = 20;
    localparam int B_INV    = 21;
    localparam int B_AUX_A  = 22;
    localparam int B_AUX_B  = 23;
    localparam int FIELD_W  = 4;
    localparam int SEL_W    = $clog2(FIELD_W);

    typedef enum logic [1:0] {
        KIND_PASS = 2'b00,
        KIND_FFIRST = 2'b01,
        KIND_RSVD = 2'b10,
        KIND_PRED = 2'b11
    } kind_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_FLUSH = 2'd2
    } state_e;

    typedef struct packed {
        kind_e            kind;
        logic             inv;
        logic             incl;
        logic             zero;
        logic [SEL_W-1:0] sel;
    } cfg_t;

endpackage

// File: rtl/crt_mode_decode.sv
module crt_mode_decode
    import crt_pkg::*;
(
    input  logic [MODE_W-1:0] mode_i,
    input  logic              is_field_i,
    input  logic [SEL_W-1:0]  dest_lo_i,
    output cfg_t              cfg_o
);

    logic unused_mode_bits;
    assign unused_mode_bits = ^{mode_i[3:0], mode_i[18:6]};

    always_comb begin
        cfg_o.kind = kind_e'({mode_i[B_KIND_H], mode_i[B_KIND_L]});
        cfg_o.inv  = mode_i[B_INV];
        if (is_field_i) begin
            cfg_o.sel  = {mode_i[B_AUX_A], mode_i[B_AUX_B]};
            cfg_o.zero = mode_i[B_DZ_FLD];
            cfg_o.incl = 1'b0;
        end else begin
            cfg_o.sel  = dest_lo_i;
            cfg_o.zero = mode_i[B_AUX_A];
            cfg_o.incl = mode_i[B_VLI];
        end
    end

endmodule

// File: rtl/crt_bit_test.sv
module crt_bit_test
    import crt_pkg::*;
(
    input  logic [FIELD_W-1:0] field_i,
    input  logic [SEL_W-1:0]   sel_i,
    input  logic               inv_i,
    output logic               pass_o
);

    logic picked;

    always_comb begin
        picked = 1'b0;
        for (int k = 0; k < FIELD_W; k++) begin
            if (sel_i == SEL_W'(k)) picked = field_i[k];
        end
        pass_o = picked ^ inv_i;
    end

endmodule

// File: rtl/crfield_trunc.sv
module crfield_trunc
    import crt_pkg::*;
#(
    parameter int MAXVL = 64,
    localparam int VL_W = $clog2(MAXVL + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [MODE_W-1:0]   mode_i,
    input  logic                is_field_i,
    input  logic [SEL_W-1:0]    dest_lo_i,
    input  logic [VL_W-1:0]     vl_i,
    input  logic                elem_valid_i,
    input  logic [FIELD_W-1:0]  elem_field_i,
    output logic                elem_ready_o,
    output logic                wr_en_o,
    output logic                wr_zero_o,
    output logic [VL_W-1:0]     wr_idx_o,
    output logic [VL_W-1:0]     vl_o,
    output logic                done_o,
    output logic                err_o
);

    localparam logic [VL_W-1:0] ONE = VL_W'(1);

    typedef struct packed {
        state_e          st;
        cfg_t            cfg;
        logic [VL_W-1:0] vl;
        logic [VL_W-1:0] idx;
        logic [VL_W-1:0] nvl;
        logic            wr_en;
        logic            wr_zero;
        logic [VL_W-1:0] wr_idx;
        logic            done;
        logic            err;
    } regs_t;

    regs_t q, d;
    cfg_t  dec_cfg;
    logic  pass;
    logic  last;

    crt_mode_decode u_dec (
        .mode_i     (mode_i),
        .is_field_i (is_field_i),
        .dest_lo_i  (dest_lo_i),
        .cfg_o      (dec_cfg)
    );

    crt_bit_test u_test (
        .field_i (elem_field_i),
        .sel_i   (q.cfg.sel),
        .inv_i   (q.cfg.inv),
        .pass_o  (pass)
    );

    assign last = (q.idx == (q.vl - ONE));

    always_comb begin
        d         = q;
        d.wr_en   = 1'b0;
        d.wr_zero = 1'b0;
        d.done    = 1'b0;
        d.err     = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    d.cfg = dec_cfg;
                    d.vl  = vl_i;
                    d.nvl = vl_i;
                    d.idx = '0;
                    if (dec_cfg.kind == KIND_RSVD) begin
                        d.done = 1'b1;
                        d.err  = 1'b1;
                    end else if (vl_i == '0) begin
                        d.done = 1'b1;
                    end else begin
                        d.st = ST_RUN;
                    end
                end
            end
            ST_RUN: begin
                if (elem_valid_i) begin
                    d.wr_idx = q.idx;
                    d.idx    = q.idx + ONE;
                    if (last) begin
                        d.done = 1'b1;
                        d.st   = ST_IDLE;
                    end
                    unique case (q.cfg.kind)
                        KIND_PRED: begin
                            d.wr_en   = pass | q.cfg.zero;
                            d.wr_zero = ~pass & q.cfg.zero;
                        end
                        KIND_FFIRST: begin
                            if (pass) begin
                                d.wr_en = 1'b1;
                            end else begin
                                d.wr_en = q.cfg.incl;
                                d.nvl   = q.cfg.incl ? (q.idx + ONE) : q.idx;
                                if (q.cfg.zero && !(q.cfg.incl && last)) begin
                                    d.st   = ST_FLUSH;
                                    d.done = 1'b0;
                                    d.idx  = q.cfg.incl ? (q.idx + ONE) : q.idx;
                                end else begin
                                    d.st   = ST_IDLE;
                                    d.done = 1'b1;
                                end
                            end
                        end
                        default: d.wr_en = 1'b1;
                    endcase
                end
            end
            ST_FLUSH: begin
                d.wr_en   = 1'b1;
                d.wr_zero = 1'b1;
                d.wr_idx  = q.idx;
                d.idx     = q.idx + ONE;
                if (last) begin
                    d.done = 1'b1;
                    d.st   = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign elem_ready_o = (q.st == ST_RUN);
    assign wr_en_o      = q.wr_en;
    assign wr_zero_o    = q.wr_zero;
    assign wr_idx_o     = q.wr_idx;
    assign vl_o         = q.nvl;
    assign done_o       = q.done;
    assign err_o        = q.err;

    AST_WRITE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> (wr_idx_o < q.vl)) else $error("write index beyond VL"); // R2
    AST_ZERO_IMPLIES_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_zero_o |-> wr_en_o) else $error("zero flag without write"); // R7
    AST_TAIL_STAYS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o && wr_zero_o && q.cfg.kind == KIND_FFIRST) |=> !(wr_en_o && !wr_zero_o))
        else $error("live write after zero tail"); // R7
    AST_VL_NEVER_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (vl_o <= q.vl)) else $error("length grew"); // R5
    AST_PRED_KEEPS_VL: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && q.cfg.kind == KIND_PRED) |-> (vl_o == q.vl)) else $error("pred changed length"); // R9
    AST_RSVD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (done_o && !wr_en_o)) else $error("reserved mode misbehaved"); // R10
    AST_DONE_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !elem_ready_o) else $error("ready during done"); // R12
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o) else $error("done longer than a cycle"); // R12

endmodule

// File: tb/tb_crfield_trunc.sv
module tb_crfield_trunc;
    import crt_pkg::*;

    localparam int CLK_P = 10;
    localparam int VLW   = 7;
    localparam int NV    = 17;

    typedef struct packed {
        logic [23:0]    mode;
        logic           fld;
        logic [1:0]     dl;
        logic [VLW-1:0] vl;
        logic           gap;
        logic [7:0]     ew;
        logic [7:0]     ez;
        logic [VLW-1:0] evl;
        logic           eerr;
    } vec_t;

    // kind {b19,b20}, invert, aux_a(b22), aux_b(b23), incl(b5), field zero(b4)
    function automatic logic [23:0] mk(input logic [1:0] k, input logic inv,
        input logic a, input logic b, input logic incl, input logic dz);
        logic [23:0] m;
        m = '0;
        m[19] = k[1]; m[20] = k[0]; m[21] = inv;
        m[22] = a; m[23] = b; m[5] = incl; m[4] = dz;
        return m;
    endfunction

    // element fields 0..7: 1,3,4,9,0,F,2,8
    localparam logic [31:0] FIELDS = 32'h82F09431;

    localparam vec_t VECS [NV] = '{
        '{mk(2'b00,0,0,0,0,0), 0, 2'd0, 7'd8, 0, 8'hFF, 8'h00, 7'd8, 0}, // R2
        '{mk(2'b01,0,0,0,0,0), 0, 2'd0, 7'd8, 0, 8'h03, 8'h00, 7'd2, 0}, // R3 R5
        '{mk(2'b01,0,0,0,1,0), 0, 2'd0, 7'd8, 0, 8'h07, 8'h00, 7'd3, 0}, // R6
        '{mk(2'b01,0,1,0,0,0), 0, 2'd0, 7'd8, 0, 8'hFF, 8'hFC, 7'd2, 0}, // R7
        '{mk(2'b01,1,1,0,1,0), 1, 2'd0, 7'd8, 0, 8'h03, 8'h00, 7'd2, 0}, // R4
        '{mk(2'b01,0,0,0,0,0), 0, 2'd3, 7'd8, 0, 8'h00, 8'h00, 7'd0, 0}, // R5 fail at 0
        '{mk(2'b01,0,0,0,0,0), 0, 2'd0, 7'd2, 0, 8'h03, 8'h00, 7'd2, 0}, // R8
        '{mk(2'b11,0,0,0,0,0), 0, 2'd1, 7'd8, 0, 8'h62, 8'h00, 7'd8, 0}, // R9
        '{mk(2'b11,0,1,0,0,0), 0, 2'd1, 7'd8, 0, 8'hFF, 8'h9D, 7'd8, 0}, // R9 zeroing
        '{mk(2'b11,1,1,1,0,1), 1, 2'd0, 7'd8, 0, 8'hFF, 8'hA8, 7'd8, 0}, // R9 R4
        '{mk(2'b10,0,0,0,0,0), 0, 2'd0, 7'd5, 0, 8'h00, 8'h00, 7'd5, 1}, // R10
        '{mk(2'b00,0,0,0,0,0), 0, 2'd0, 7'd0, 0, 8'h00, 8'h00, 7'd0, 0}, // R11
        '{mk(2'b01,1,1,0,1,0), 0, 2'd2, 7'd3, 0, 8'h07, 8'h00, 7'd3, 0}, // R6 last element
        '{mk(2'b01,1,1,0,0,0), 0, 2'd2, 7'd3, 0, 8'h07, 8'h04, 7'd2, 0}, // R7 last element
        '{mk(2'b00,0,0,0,0,0), 0, 2'd0, 7'd5, 1, 8'h1F, 8'h00, 7'd5, 0}, // R12 gapped
        '{mk(2'b01,0,0,0,0,0), 0, 2'd0, 7'd8, 1, 8'h03, 8'h00, 7'd2, 0}, // R12 gapped
        '{mk(2'b01,0,0,0,0,1), 1, 2'd0, 7'd8, 0, 8'hFF, 8'hFC, 7'd2, 0}  // R7 R4
    };

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic [23:0]    mode = '0;
    logic           is_field = 1'b0;
    logic [1:0]     dest_lo = '0;
    logic [VLW-1:0] vl_in = '0;
    logic           elem_valid = 1'b0;
    logic [3:0]     elem_field = '0;
    logic           ready, wr_en, wr_zero, done, err;
    logic [VLW-1:0] wr_idx, vl_out;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_P/2) clk = ~clk;

    crfield_trunc dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .mode_i(mode),
        .is_field_i(is_field), .dest_lo_i(dest_lo), .vl_i(vl_in),
        .elem_valid_i(elem_valid), .elem_field_i(elem_field),
        .elem_ready_o(ready), .wr_en_o(wr_en), .wr_zero_o(wr_zero),
        .wr_idx_o(wr_idx), .vl_o(vl_out), .done_o(done), .err_o(err)
    );

    task automatic chk(input bit ok, input string req, input int vi,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s vec %0d: got %0h expected %0h", req, vi, act, exp);
        end
    endtask

    task automatic run_vec(input vec_t v, input int vi);
        logic [7:0]     gw = '0;
        logic [7:0]     gz = '0;
        logic [VLW-1:0] gvl = '0;
        logic           gerr = 1'b0;
        bit             fin = 0;
        int             acc = 0;
        @(negedge clk);
        mode = v.mode; is_field = v.fld; dest_lo = v.dl; vl_in = v.vl;
        start = 1'b1; elem_valid = 1'b0;
        @(negedge clk);
        start = 1'b0;
        for (int c = 0; c < 40 && !fin; c++) begin
            if (wr_en) begin
                gw[wr_idx[2:0]] = 1'b1;
                if (wr_zero) gz[wr_idx[2:0]] = 1'b1;
            end
            if (done) begin
                fin = 1; gvl = vl_out; gerr = err; elem_valid = 1'b0;
            end else begin
                elem_valid = v.gap ? c[0] : 1'b1;
                elem_field = (acc < 8) ? FIELDS[acc*4 +: 4] : 4'h0;
                if (elem_valid && ready) acc++;
                @(negedge clk);
            end
        end
        elem_valid = 1'b0;
        chk(fin, "R12 done seen", vi, int'(fin), 1);
        chk(gw == v.ew, "write mask", vi, int'(gw), int'(v.ew));
        chk(gz == v.ez, "zero mask", vi, int'(gz), int'(v.ez));
        chk(gvl == v.evl, "final length", vi, int'(gvl), int'(v.evl));
        chk(gerr == v.eerr, "R10 error flag", vi, int'(gerr), int'(v.eerr));
        @(negedge clk);
        chk(!done && !ready && !wr_en, "R12 single done pulse", vi,
            int'({done, ready, wr_en}), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!ready && !wr_en && !wr_zero && !done && !err, "R1 reset state", -1,
            int'({ready, wr_en, wr_zero, done, err}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!ready && !done, "R1 idle after release", -1, int'({ready, done}), 0);
        for (int i = 0; i < NV; i++) run_vec(VECS[i], i);
        // R12: start while busy is ignored; a second start mid-run changes nothing
        @(negedge clk);
        mode = mk(2'b00,0,0,0,0,0); is_field = 1'b0; vl_in = 7'd2; start = 1'b1;
        @(negedge clk);
        start = 1'b1; vl_in = 7'd0; mode = mk(2'b10,0,0,0,0,0);
        elem_valid = 1'b1; elem_field = 4'h1;
        @(negedge clk);
        start = 1'b0;
        chk(wr_en && !err && !done, "R12 busy start ignored", 100,
            int'({wr_en, err, done}), 4);
        @(negedge clk);
        elem_valid = 1'b0;
        chk(done && !err && vl_out == 7'd2, "R12 busy start ignored", 101,
            int'(vl_out), 2);
        @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_P * 50000);
        n_bad++;
        $display("FAIL R12 watchdog: got hang expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule